// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives a slower clock from its input clock. The output stays high for a programmed number of input cycles and then low for a separately programmed number, so both the division ratio and the duty cycle can be chosen. A synchronisation input realigns the waveform. While realignment is active, the output holds a selectable starting level. After it is released, a programmable phase delay of whole input cycles is inserted before the waveform runs. A bypass setting routes the input clock straight to the output.

Two 8-bit configuration bytes are written through a simple write port. The timing byte holds the two period counts. The control byte holds the phase delay, the starting level, and the bypass, sync-ignore and one-shot force flags. Count changes are staged and take effect only at the start of a new high phase, so reprogramming never produces a short pulse.

Top module: `pdc_divider`

## Requirements
- R1: A synchronous active-high reset clears both bytes. This gives high and low counts of 0, phase 0, start low, no bypass and sync honoured. The output is low during reset, and afterwards it toggles on every input rising edge (divide-by-2).
- R2: Each high phase of the output lasts (high count + 1) input cycles. The high count is bits 3:0 of the timing byte.
- R3: Each low phase lasts (low count + 1) input cycles. The low count is bits 7:4 of the timing byte.
- R4: A write with `cfg_we`=1 stores `cfg_data` on the rising clock edge. It goes to the timing byte when `cfg_sel`=0 and to the control byte when `cfg_sel`=1.
- R5: While `sync_in` is high and sync is honoured, the output is held at the start level.
- R6: Count the first rising edge at which sync is seen low as edge 1. The first output transition happens after edge (phase + start-level length), where phase is control bits 3:0 and the start-level length is count + 1 for the start level. The waveform then alternates normally.
- R7: Control bit 4 selects the start level: 1 means high, 0 means low.
- R8: When control bit 6 is set, `sync_in` has no effect and the running waveform continues unchanged.
- R9: Writing the control byte with bit 7 set realigns the divider once, as if sync were seen for one cycle on the following edge. This happens even if bit 6 is set.
- R10: When control bit 5 is set, `clk_out` equals `clk` and the counters are held in realignment. Clearing the bit resumes the waveform as after a sync release (R6).
- R11: A new timing byte is applied at the next low-to-high output transition, or at realignment. The high and low phases already in progress complete with the old counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Byte select: 0 timing, 1 control |
| cfg_data | input | 8 | Configuration byte value |
| sync_in | input | 1 | Realignment request, active high |
| clk_out | output | 1 | Divided (or bypassed) clock |

## Verification
A corrupted cycle counter shows up at once in the length of the current output phase, one period after the fault at the latest. A wrong phase counter or start level is seen in the first transition after a sync release, within phase plus sixteen cycles. Staged counts that are applied at the wrong moment distort the first period after a reprogramming. Because of this, the bench measures run lengths straight after each write, release and mode change.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  parameter int CNT_W  = 4;
  localparam int BYTE_W = 2 * CNT_W;
  localparam int START_BIT  = CNT_W;
  localparam int BYPASS_BIT = CNT_W + 1;
  localparam int NOSYNC_BIT = CNT_W + 2;
  localparam int FORCE_BIT  = CNT_W + 3;

  typedef struct packed {
    logic [CNT_W-1:0] lo;
    logic [CNT_W-1:0] hi;
  } timing_t;

  typedef struct packed {
    logic             nosync;
    logic             bypass;
    logic             start;
    logic [CNT_W-1:0] phase;
  } ctrl_t;

  // Last counter index of the phase currently driven (length minus one).
  function automatic logic [CNT_W-1:0] last_idx(input logic level, input timing_t t);
    return level ? t.hi : t.lo;
  endfunction
endpackage

// File: rtl/pdc_cfg_regs.sv
module pdc_cfg_regs
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              sel,
  input  logic [BYTE_W-1:0] data,
  output timing_t           tim,
  output ctrl_t             ctl,
  output logic              force_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tim     <= '0;
      ctl     <= '0;
      force_q <= 1'b0;
    end else begin
      force_q <= we & sel & data[FORCE_BIT];
      if (we && !sel) begin
        tim.lo <= data[BYTE_W-1:CNT_W];
        tim.hi <= data[CNT_W-1:0];
      end
      if (we && sel) begin
        ctl.phase  <= data[CNT_W-1:0];
        ctl.start  <= data[START_BIT];
        ctl.bypass <= data[BYPASS_BIT];
        ctl.nosync <= data[NOSYNC_BIT];
      end
    end
  end
endmodule

// File: rtl/pdc_div_core.sv
module pdc_div_core
  import pdc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  timing_t          tim_pend,
  input  logic [CNT_W-1:0] ph_pend,
  input  logic             start_pend,
  output logic             q,
  output logic             toggle_ev,
  output logic             load_ev,
  output logic [CNT_W-1:0] cnt_o,
  output timing_t          act_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] extra;
  timing_t          act;
  logic             at_end;

  assign at_end    = (extra == '0) && (cnt == last_idx(q, act));
  assign toggle_ev = !hold && at_end;
  assign load_ev   = hold || (toggle_ev && !q);
  assign cnt_o     = cnt;
  assign act_o     = act;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      cnt   <= '0;
      extra <= '0;
      act   <= '0;
    end else if (hold) begin
      q     <= start_pend;
      cnt   <= '0;
      extra <= ph_pend;
      act   <= tim_pend;
    end else if (extra != '0) begin
      extra <= extra - 1'b1;
    end else if (at_end) begin
      q   <= !q;
      cnt <= '0;
      if (!q) act <= tim_pend;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pdc_divider.sv
module pdc_divider
  import pdc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [BYTE_W-1:0] cfg_data,
  input  logic              sync_in,
  output logic              clk_out
);
  timing_t          tim;
  ctrl_t            ctl;
  logic             force_q;
  logic             sync_eff;
  logic             div_q;
  logic             toggle_ev;
  logic             load_ev;
  logic [CNT_W-1:0] cnt;
  timing_t          act;

  pdc_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
    .tim(tim), .ctl(ctl), .force_q(force_q)
  );

  assign sync_eff = (sync_in && !ctl.nosync) || force_q || ctl.bypass;

  pdc_div_core u_core (
    .clk(clk), .rst(rst), .hold(sync_eff),
    .tim_pend(tim), .ph_pend(ctl.phase), .start_pend(ctl.start),
    .q(div_q), .toggle_ev(toggle_ev), .load_ev(load_ev),
    .cnt_o(cnt), .act_o(act)
  );

  assign clk_out = ctl.bypass ? clk : div_q;
endmodule

// File: rtl/pdc_divider_chk.sv
module pdc_divider_chk
  import pdc_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             sync_eff,
  input logic             bypass,
  input logic             start_pend,
  input logic             q,
  input logic             toggle_ev,
  input logic             load_ev,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] act_hi,
  input logic [CNT_W-1:0] act_lo
);
  p_hold_start_r5: assert property (@(posedge clk) disable iff (rst)
    sync_eff |=> (q == $past(start_pend)));

  p_q_moves_on_event_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> $past(toggle_ev || sync_eff));

  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= (q ? act_hi : act_lo));

  p_cfg_at_boundary_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable({act_hi, act_lo}) |-> $past(load_ev));

  p_bypass_holds_r10: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (cnt == '0));
endmodule

bind pdc_divider pdc_divider_chk u_chk (
  .clk(clk), .rst(rst), .sync_eff(sync_eff), .bypass(ctl.bypass),
  .start_pend(ctl.start), .q(div_q), .toggle_ev(toggle_ev),
  .load_ev(load_ev), .cnt(cnt), .act_hi(act.hi), .act_lo(act.lo)
);

// File: tb/sim_pdc_divider.sv
`timescale 1ns/1ps
module sim_pdc_divider;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic cfg_sel = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic sync_in = 1'b0;
  logic clk_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pdc_divider u0 (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
                  .cfg_data(cfg_data), .sync_in(sync_in), .clk_out(clk_out));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk); sync_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (clk_out == lvl && n < 80) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Measures first run, then the other level, then start level again.
  task automatic measure(input string tag, input logic st, input int ph, input int hi, input int lo);
    int n;
    int ls, lx;
    ls = st ? hi + 1 : lo + 1;
    lx = st ? lo + 1 : hi + 1;
    run_len(st, n);  chk({tag, " first run"}, n, ph + ls - 1);
    run_len(!st, n); chk({tag, " second run"}, n, lx);
    run_len(st, n);  chk({tag, " third run"}, n, ls);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int lo;
    logic st;
    // R1: reset state and default divide-by-2
    repeat (4) @(negedge clk);
    chk("R1 out low in reset", clk_out, 0);
    rst = 1'b0;
    @(negedge clk);
    run_len(1'b1, n); chk("R1 default high run", n, 1);
    run_len(1'b0, n); chk("R1 default low run", n, 1);

    // R2 R3 R4: all high/low counts, phase 0, start low
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        wr(1'b0, 8'((l << 4) | h));
        wr(1'b1, 8'h00);
        do_sync();
        measure("R2 R3 R4 sweep", 1'b0, 0, h, l);
      end
    end

    // R5 R6 R7: phase offsets with both start levels
    for (int p = 0; p < 16; p++) begin
      for (int h = 0; h < 16; h++) begin
        lo = (h + p) % 16;
        st = p[0];
        wr(1'b0, 8'((lo << 4) | h));
        wr(1'b1, 8'((int'(st) << 4) | p));
        do_sync();
        measure("R5 R6 R7 phase", st, p, h, lo);
      end
    end

    // R8: sync ignored when bit 6 set (hi=2 lo=2)
    wr(1'b0, 8'h22);
    wr(1'b1, 8'h00);
    do_sync();
    wr(1'b1, 8'h40);
    begin
      logic prev;
      prev = clk_out;
      n = 0;
      @(negedge clk);
      while (!(prev == 1'b0 && clk_out == 1'b1) && n < 40) begin
        prev = clk_out; n++; @(negedge clk);
      end
      sync_in = 1'b1;
      for (int j = 1; j < 12; j++) begin
        @(negedge clk);
        if (j == 4) sync_in = 1'b0;
        chk("R8 sync ignored", clk_out, ((j % 6) < 3) ? 1 : 0);
      end
      sync_in = 1'b0;
    end

    // R9: force realign with sync-ignore set: hi=2 lo=1 phase 3 start high
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h40 | 8'h10 | 8'h03);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'hC0 | 8'h10 | 8'h03);
    repeat (2) @(negedge clk);
    measure("R9 force", 1'b1, 3, 2, 1);

    // R11: counts change at the next rising output edge (old hi=1 lo=1, new 3/3)
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    do_sync();
    begin
      logic prev;
      logic exp_seq [12];
      exp_seq = '{1,1,0,0,1,1,1,1,0,0,0,0};
      prev = clk_out;
      n = 0;
      @(negedge clk);
      while (!(prev == 1'b0 && clk_out == 1'b1) && n < 40) begin
        prev = clk_out; n++; @(negedge clk);
      end
      chk("R11 boundary j0", clk_out, 1);
      cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 8'h33;
      for (int j = 1; j < 12; j++) begin
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R11 boundary", clk_out, exp_seq[j]);
      end
    end

    // R10: bypass follows clock, then resumes like a sync release
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h22);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #5;
      chk("R10 bypass high", clk_out, 1);
      @(negedge clk); #5;
      chk("R10 bypass low", clk_out, 0);
    end
    wr(1'b1, 8'h02);
    @(negedge clk);
    measure("R10 resume", 1'b0, 2, 0, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule